// File: doc/BRIEF.md
# Descriptor Memory Access Controller

This block lets two requesters share one single-port synchronous RAM that holds DMA transfer descriptors. The DMA engine reads and writes whole 64-bit words. A peripheral register bus reads and writes 32-bit halves of those words. Each requester has its own request, write-enable, address, write-data, read-data and ready signals, so each sees what looks like a private port. The RAM is 64 bits wide so that a four-word descriptor can be fetched in four accesses.

The RAM serves one access per cycle. When both requesters ask in the same cycle, the engine is served and the peripheral access is stalled. The peripheral requester keeps its request asserted, and its access completes in the first cycle in which the engine does not request the RAM. Ready and read data appear together, one cycle after the cycle in which the RAM serves the access.

The arbiter is a three-state machine. The state records which requester owns the data phase in the current cycle:
- `ST_IDLE`: nobody owns it.
- `ST_ENG_DATA`: the engine owns it.
- `ST_PER_DATA`: the peripheral owns it.

The arbiter takes its next state from every state in the same way, with the engine taking precedence:
- Engine-grant: any state moves to `ST_ENG_DATA` when the engine requests.
- Peripheral-grant: any state moves to `ST_PER_DATA` when only the peripheral requests.
- Release: any state moves to `ST_IDLE` when there is no request.

Top module: `desc_mem_ctrl`

## Requirements
- R1: After reset, with no request asserted, `eng_rdy` and `per_rdy` are both low.
- R2: An engine request at a rising edge gives `eng_rdy` high in the following cycle. On a read, that cycle also carries the addressed 64-bit word on `eng_rdata`.
- R3: The word address used for an engine access is `eng_chan` × 4 + `eng_word`. A peripheral access to 32-bit address a reaches word a/2 of that same storage.
- R4: An engine write replaces all 64 bits of the addressed word. A later read returns the new value.
- R5: On a peripheral read, `per_addr[0]`=0 returns bits 31:0 of the word and `per_addr[0]`=1 returns bits 63:32. The data arrives with `per_rdy`, one cycle after the access is served.
- R6: A peripheral write changes only the 32-bit half selected by `per_addr[0]`. The other half of the word keeps its value.
- R7: When both requesters ask at the same edge, the engine is served. In the following cycle `eng_rdy` is high and `per_rdy` is low.
- R8: A stalled peripheral request that is held is served at the first edge at which `eng_req` is low. `per_rdy` rises in the cycle after that edge, carrying correct data.
- R9: `eng_rdy` and `per_rdy` are never high in the same cycle. Each ready is high only in the cycle after an edge at which that requester was served.
- R10: A peripheral write that was stalled is not lost. Once it completes, its half of the word holds the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_req | input | 1 | Engine access request |
| eng_we | input | 1 | Engine write (1) or read (0) |
| eng_chan | input | 5 | Engine channel number |
| eng_word | input | 2 | Engine word index within descriptor |
| eng_wdata | input | 64 | Engine write data |
| eng_rdata | output | 64 | Engine read data |
| eng_rdy | output | 1 | Engine access complete |
| per_req | input | 1 | Peripheral access request, held until ready |
| per_we | input | 1 | Peripheral write (1) or read (0) |
| per_addr | input | 8 | Peripheral 32-bit address; bit 0 picks the half |
| per_wdata | input | 32 | Peripheral write data |
| per_rdata | output | 32 | Peripheral read data |
| per_rdy | output | 1 | Peripheral access complete |

## Verification
The bench drives simultaneous requests and checks that the engine alone is acknowledged. A design that gave the peripheral priority, or acknowledged both requesters, would show `per_rdy` in the collision cycle. It holds the engine on the RAM for several back-to-back cycles and checks that the pending peripheral access completes exactly one cycle after the engine lets go. A design that dropped the stalled access, or served it late, would never raise `per_rdy` in that cycle, or would raise it in the wrong cycle. Half-word writes, both plain and stalled, are read back through the engine port. A design that wrote both halves, chose the wrong half, or lost the stalled data would return a word that differs from the expected merge.

// File: rtl/desc_mem_pkg.sv
package desc_mem_pkg;
    localparam int WORD_W = 64;
    localparam int HALF_W = 32;
    localparam int LANES  = WORD_W / HALF_W;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ENG_DATA = 2'd1,
        ST_PER_DATA = 2'd2
    } arb_state_e;
endpackage

// File: rtl/desc_ram.sv
module desc_ram
    import desc_mem_pkg::*;
#(
    parameter int DEPTH  = 128,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              en,
    input  logic [LANES-1:0]  we,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] q
);
    for (genvar h = 0; h < LANES; h++) begin : g_lane
        logic [HALF_W-1:0] store [DEPTH];
        logic [HALF_W-1:0] q_l;

        always_ff @(posedge clk) begin
            if (en) begin
                if (we[h]) begin
                    store[addr] <= wdata[h*HALF_W +: HALF_W];
                end
                q_l <= store[addr];
            end
        end

        assign q[h*HALF_W +: HALF_W] = q_l;
    end
endmodule

// File: rtl/desc_addr_map.sv
module desc_addr_map #(
    parameter int NUM_CH     = 32,
    parameter int DESC_WORDS = 4,
    localparam int CH_W      = $clog2(NUM_CH),
    localparam int WD_W      = $clog2(DESC_WORDS),
    localparam int AW        = $clog2(NUM_CH * DESC_WORDS)
) (
    input  logic [CH_W-1:0] chan,
    input  logic [WD_W-1:0] word,
    input  logic [AW:0]     per_addr,
    output logic [AW-1:0]   eng_wa,
    output logic [AW-1:0]   per_wa,
    output logic            per_half
);
    assign eng_wa   = AW'(chan) * AW'(DESC_WORDS) + AW'(word);
    assign per_wa   = per_addr[AW:1];
    assign per_half = per_addr[0];
endmodule

// File: rtl/desc_mem_arb.sv
module desc_mem_arb
    import desc_mem_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eng_req,
    input  logic              eng_we,
    input  logic [AW-1:0]     eng_wa,
    input  logic [WORD_W-1:0] eng_wdata,
    input  logic              per_req,
    input  logic              per_we,
    input  logic [AW-1:0]     per_wa,
    input  logic              per_half,
    input  logic [HALF_W-1:0] per_wdata,
    output logic              ram_en,
    output logic [LANES-1:0]  ram_we,
    output logic [AW-1:0]     ram_addr,
    output logic [WORD_W-1:0] ram_wdata,
    output logic              eng_rdy,
    output logic              per_rdy
);
    arb_state_e state_q, state_d;

    always_comb begin
        if (eng_req)      state_d = ST_ENG_DATA;
        else if (per_req) state_d = ST_PER_DATA;
        else              state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        eng_rdy   = 1'b0;
        per_rdy   = 1'b0;
        ram_en    = 1'b0;
        ram_we    = '0;
        ram_addr  = eng_wa;
        ram_wdata = eng_wdata;
        unique case (state_q)
            ST_IDLE:     ;
            ST_ENG_DATA: eng_rdy = 1'b1;
            ST_PER_DATA: per_rdy = 1'b1;
            default:     ;
        endcase
        unique case (state_d)
            ST_IDLE: ;
            ST_ENG_DATA: begin
                ram_en = 1'b1;
                ram_we = {LANES{eng_we}};
            end
            ST_PER_DATA: begin
                ram_en    = 1'b1;
                ram_addr  = per_wa;
                ram_wdata = {LANES{per_wdata}};
                ram_we    = per_we ? (LANES'(1) << per_half) : '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/desc_mem_ctrl.sv
module desc_mem_ctrl
    import desc_mem_pkg::*;
#(
    parameter int NUM_CH     = 32,
    parameter int DESC_WORDS = 4,
    localparam int CH_W      = $clog2(NUM_CH),
    localparam int WD_W      = $clog2(DESC_WORDS),
    localparam int DEPTH     = NUM_CH * DESC_WORDS,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eng_req,
    input  logic              eng_we,
    input  logic [CH_W-1:0]   eng_chan,
    input  logic [WD_W-1:0]   eng_word,
    input  logic [WORD_W-1:0] eng_wdata,
    output logic [WORD_W-1:0] eng_rdata,
    output logic              eng_rdy,
    input  logic              per_req,
    input  logic              per_we,
    input  logic [AW:0]       per_addr,
    input  logic [HALF_W-1:0] per_wdata,
    output logic [HALF_W-1:0] per_rdata,
    output logic              per_rdy
);
    logic [AW-1:0]     eng_wa, per_wa, ram_addr;
    logic              per_half, half_q, ram_en;
    logic [LANES-1:0]  ram_we;
    logic [WORD_W-1:0] ram_wdata, ram_q;

    desc_addr_map #(.NUM_CH(NUM_CH), .DESC_WORDS(DESC_WORDS)) u_map (
        .chan(eng_chan), .word(eng_word), .per_addr(per_addr),
        .eng_wa(eng_wa), .per_wa(per_wa), .per_half(per_half)
    );

    desc_mem_arb #(.AW(AW)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .eng_req(eng_req), .eng_we(eng_we), .eng_wa(eng_wa), .eng_wdata(eng_wdata),
        .per_req(per_req), .per_we(per_we), .per_wa(per_wa), .per_half(per_half),
        .per_wdata(per_wdata),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .eng_rdy(eng_rdy), .per_rdy(per_rdy)
    );

    desc_ram #(.DEPTH(DEPTH)) u_ram (
        .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
        .wdata(ram_wdata), .q(ram_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                  half_q <= 1'b0;
        else if (per_req && !eng_req) half_q <= per_half;
    end

    assign eng_rdata = ram_q;
    assign per_rdata = ram_q[HALF_W*half_q +: HALF_W];
endmodule

// File: rtl/desc_mem_ctrl_chk.sv
module desc_mem_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic eng_req,
    input logic per_req,
    input logic eng_rdy,
    input logic per_rdy
);
    p_eng_served_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |=> eng_rdy);
    p_eng_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_req |=> !eng_rdy);
    p_collision_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && per_req) |=> !per_rdy);
    p_per_served_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (per_req && !eng_req) |=> per_rdy);
    p_rdy_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eng_rdy, per_rdy}));
endmodule

bind desc_mem_ctrl desc_mem_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .eng_req(eng_req), .per_req(per_req),
    .eng_rdy(eng_rdy), .per_rdy(per_rdy)
);

// File: tb/tb_desc_mem_ctrl.sv
module tb_desc_mem_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eng_req = 1'b0, eng_we = 1'b0;
    logic [4:0]  eng_chan = '0;
    logic [1:0]  eng_word = '0;
    logic [63:0] eng_wdata = '0, eng_rdata;
    logic        eng_rdy;
    logic        per_req = 1'b0, per_we = 1'b0;
    logic [7:0]  per_addr = '0;
    logic [31:0] per_wdata = '0, per_rdata;
    logic        per_rdy;

    logic [63:0] mdl [128];
    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    desc_mem_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .eng_req(eng_req), .eng_we(eng_we), .eng_chan(eng_chan), .eng_word(eng_word),
        .eng_wdata(eng_wdata), .eng_rdata(eng_rdata), .eng_rdy(eng_rdy),
        .per_req(per_req), .per_we(per_we), .per_addr(per_addr),
        .per_wdata(per_wdata), .per_rdata(per_rdata), .per_rdy(per_rdy)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic eng_xfer(input bit we, input int ch, input int w, input logic [63:0] d,
                            output logic [63:0] rd);
        @(negedge clk);
        eng_req = 1'b1; eng_we = we; eng_chan = 5'(ch); eng_word = 2'(w); eng_wdata = d;
        @(negedge clk);
        chk(eng_rdy === 1'b1, "R2 eng_rdy", 64'(eng_rdy), 64'd1);
        rd = eng_rdata;
        eng_req = 1'b0; eng_we = 1'b0;
        if (we) mdl[ch*4+w] = d;
    endtask

    task automatic per_xfer(input bit we, input int a, input logic [31:0] d, output logic [31:0] rd);
        int guard;
        @(negedge clk);
        per_req = 1'b1; per_we = we; per_addr = 8'(a); per_wdata = d;
        guard = 0;
        do begin @(negedge clk); guard++; end while (!per_rdy && guard < 20);
        chk(per_rdy === 1'b1, "R5 per_rdy", 64'(per_rdy), 64'd1);
        rd = per_rdata;
        per_req = 1'b0; per_we = 1'b0;
        if (we) begin
            if (a % 2) mdl[a/2][63:32] = d;
            else       mdl[a/2][31:0]  = d;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(eng_rdy === 1'b0, "R1 eng_rdy", 64'(eng_rdy), 0);
        chk(per_rdy === 1'b0, "R1 per_rdy", 64'(per_rdy), 0);
    endtask

    task automatic t_engine();
        logic [63:0] r;
        logic [31:0] p;
        eng_xfer(1, 0, 0, 64'h0123_4567_89AB_CDEF, r);
        eng_xfer(1, 7, 3, 64'hDEAD_BEEF_CAFE_F00D, r);
        eng_xfer(1, 31, 3, 64'hFFFF_0000_AAAA_5555, r);
        eng_xfer(1, 7, 2, 64'h1111_2222_3333_4444, r);
        eng_xfer(0, 7, 3, 0, r);
        chk(r === mdl[31], "R2 R4 read 7/3", r, mdl[31]);
        eng_xfer(0, 31, 3, 0, r);
        chk(r === mdl[127], "R2 R4 read 31/3", r, mdl[127]);
        eng_xfer(0, 0, 0, 0, r);
        chk(r === mdl[0], "R2 read 0/0", r, mdl[0]);
        @(negedge clk);
        chk(eng_rdy === 1'b0, "R9 eng_rdy idle", 64'(eng_rdy), 0);
        per_xfer(0, 31*2, 0, p);
        chk(p === mdl[31][31:0], "R3 R5 low half", 64'(p), 64'(mdl[31][31:0]));
        per_xfer(0, 31*2+1, 0, p);
        chk(p === mdl[31][63:32], "R3 R5 high half", 64'(p), 64'(mdl[31][63:32]));
        per_xfer(0, 30*2+1, 0, p);
        chk(p === mdl[30][63:32], "R3 R5 word 30", 64'(p), 64'(mdl[30][63:32]));
    endtask

    task automatic t_per_write();
        logic [63:0] r;
        logic [31:0] p;
        per_xfer(1, 30*2, 32'hA5A5_0F0F, p);
        eng_xfer(0, 7, 2, 0, r);
        chk(r === mdl[30], "R6 low half write", r, mdl[30]);
        per_xfer(1, 0*2+1, 32'h7777_8888, p);
        eng_xfer(0, 0, 0, 0, r);
        chk(r === mdl[0], "R6 high half write", r, mdl[0]);
    endtask

    task automatic t_collision(input bit we);
        logic [63:0] r;
        @(negedge clk);
        eng_req = 1'b1; eng_we = 1'b0; eng_chan = 5'd7; eng_word = 2'd3;
        per_req = 1'b1; per_we = we; per_addr = 8'(127*2+1); per_wdata = 32'h5A5A_C3C3;
        @(negedge clk);
        chk(eng_rdy === 1'b1, "R7 eng wins", 64'(eng_rdy), 1);
        chk(per_rdy === 1'b0, "R7 per stalled", 64'(per_rdy), 0);
        chk(eng_rdata === mdl[31], "R7 eng data", eng_rdata, mdl[31]);
        eng_chan = 5'd31;
        @(negedge clk);
        chk(per_rdy === 1'b0, "R7 still stalled", 64'(per_rdy), 0);
        chk(eng_rdata === mdl[127], "R2 back-to-back", eng_rdata, mdl[127]);
        eng_chan = 5'd0; eng_word = 2'd0;
        @(negedge clk);
        chk(per_rdy === 1'b0, "R7 still stalled 2", 64'(per_rdy), 0);
        eng_req = 1'b0;
        @(negedge clk);
        chk(per_rdy === 1'b1, "R8 per completes", 64'(per_rdy), 1);
        chk(eng_rdy === 1'b0, "R9 eng_rdy low", 64'(eng_rdy), 0);
        if (!we) chk(per_rdata === mdl[127][63:32], "R8 stalled data",
                     64'(per_rdata), 64'(mdl[127][63:32]));
        else mdl[127][63:32] = 32'h5A5A_C3C3;
        per_req = 1'b0; per_we = 1'b0;
        @(negedge clk);
        chk(per_rdy === 1'b0, "R9 per_rdy drops", 64'(per_rdy), 0);
        if (we) begin
            eng_xfer(0, 31, 3, 0, r);
            chk(r === mdl[127], "R10 stalled write kept", r, mdl[127]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_engine();
        t_per_write();
        t_collision(1'b0);
        t_collision(1'b1);
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule